// File: doc/BRIEF.md
# Access-Code Protected Watchdog Timer

This block is a two-stage system watchdog on a simple 32-bit register bus. Software arms it with a trigger write. A 17-bit counter is then loaded with the sum of two programmed timeouts. The counter counts down once per prescaler period, which is 10000 clock cycles by default. When the first timeout has elapsed, the counter has reached the reset-timeout value and an interrupt is raised. When the counter reaches zero, a sticky reset request goes out to the system reset logic.

Every write to the control word must carry the current 20-bit access code. A 20-bit maximal-length shift register produces this code. Reading the control word shows the current code, and each accepted control write moves the generator on by one step, so each code works for one write only. A control write with the wrong code has no effect of any kind. The two timeout words take writes only while a write-enable flag is on, and only an accepted control write can turn that flag on. The interrupt has a raw status word, a masked view of it, and separate set and clear words for its mask.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the following all read 0: the counter, both timeouts, raw status, mask, write-enable flag, `irq_o` and `rst_req_o`. The control word's code field reads the seed value 0x5A5A5.
- R2: A read at offset 0x00 returns the current access code in bits [19:0], the raw interrupt in bit 24 and the write-enable flag in bit 31. Bit 28 and all other bits read 0.
- R3: A write at offset 0x00 is accepted only when bits [19:0] equal the current code. A write with a mismatched code changes nothing: it does not trigger, does not clear the interrupt, does not change the write-enable flag and does not advance the code.
- R4: Each accepted control write replaces code c with {c[18:0], c[19]^c[16]}. A code that has been used once is then rejected.
- R5: Bit 31 of an accepted control write sets the write-enable flag when 1 and clears it when 0. Writes to 0x08 (interrupt timeout, bits [15:0]) and 0x0C (reset timeout, bits [15:0]) are ignored while the flag is 0.
- R6: An accepted control write with bit 28 set loads the counter with interrupt timeout + reset timeout. The counter reads at 0x04 bits [16:0] and decrements by one every TICK_DIV cycles after the load.
- R7: The raw interrupt (0x10 bit 0) sets on the tick at which the counter reaches the reset timeout, that is, interrupt-timeout ticks after the trigger.
- R8: `rst_req_o` rises on the tick at which the counter reaches 0. It stays high until reset, and a later trigger does not clear it.
- R9: While either timeout is 0, the counter holds its value and neither event occurs.
- R10: Writing 1 to 0x10 bit 0 clears the raw interrupt, and writing 0 leaves it unchanged. An accepted control write with bit 24 set also clears it.
- R11: Writing 1 to bit 0 at 0x18 sets the mask, and writing 1 to bit 0 at 0x1C clears it. Writing 0 to either has no effect, and both words read the mask. 0x14 and `irq_o` show raw AND mask.
- R12: An accepted trigger during a countdown reloads the full sum. An accepted control write without bit 28 leaves the countdown running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | ADDR_W | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | Masked watchdog interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The access-code check is tried three ways: with the live code, with a made-up code, and with a code that was valid one step earlier. This separates a correct compare from one that is too loose and from a generator that fails to step. The countdown runs with unequal interrupt and reset timeouts, so a swapped load or a wrong event threshold shows up at the exact cycle. It is also run with a zero timeout, with a mid-run retrigger, and with a valid write that has no trigger bit. Clears and mask writes each go in with both 0 and 1, so an unqualified write shows up as a changed flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL    = 3'd0,
    IDX_COUNT   = 3'd1,
    IDX_IRQ_TO  = 3'd2,
    IDX_RES_TO  = 3'd3,
    IDX_RAW     = 3'd4,
    IDX_MASKED  = 3'd5,
    IDX_MSK_SET = 3'd6,
    IDX_MSK_CLR = 3'd7
  } reg_idx_e;

  localparam int unsigned BIT_IRQ  = 24;
  localparam int unsigned BIT_TRIG = 28;
  localparam int unsigned BIT_WEN  = 31;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == LAST);
  assign tick_o = wrap && !clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (wrap)  cnt_d = '0;
    else if (en_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6
endmodule

// File: rtl/wdt_codegen.sv
module wdt_codegen #(
  parameter int unsigned W     = 20,
  parameter int unsigned TAP_A = 20,
  parameter int unsigned TAP_B = 17,
  parameter logic [W-1:0] SEED = 20'h5A5A5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] sr_q, sr_d;
  logic         fb;

  assign fb = sr_q[TAP_A-1] ^ sr_q[TAP_B-1];

  always_comb begin
    sr_d = sr_q;
    if (adv_i) sr_d = {sr_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= SEED;
    else        sr_q <= sr_d;
  end

  assign code_o = sr_q;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(code_o)); // R4
  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    code_o != '0); // R4
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned TO_W  = 16,
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [TO_W-1:0]  irq_to_i,
  input  logic [TO_W-1:0]  res_to_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             irq_hit_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, load_val, cnt_dec, res_ext;
  logic             armed_q, armed_d;
  logic             rst_q, rst_d;
  logic             to_valid, step;

  assign load_val = CNT_W'(irq_to_i) + CNT_W'(res_to_i);
  assign res_ext  = CNT_W'(res_to_i);
  assign cnt_dec  = cnt_q - 1'b1;
  assign to_valid = (irq_to_i != '0) && (res_to_i != '0);
  assign run_o    = armed_q && to_valid && (cnt_q != '0);
  assign step     = run_o && tick_i && !trig_i;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    rst_d   = rst_q;
    if (trig_i) begin
      cnt_d   = load_val;
      armed_d = 1'b1;
    end else if (step) begin
      cnt_d = cnt_dec;
      if (cnt_dec == '0) rst_d = 1'b1;
    end
  end

  assign irq_hit_o = step && (cnt_dec == res_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      rst_q   <= rst_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_q;

  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> cnt_q == $past(load_val)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q); // R8
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_valid && !trig_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned TICK_DIV = 10000,
  parameter int unsigned CODE_W   = 20,
  parameter int unsigned TO_W     = 16,
  parameter int unsigned CNT_W    = 17,
  parameter logic [CODE_W-1:0] CODE_SEED = 20'h5A5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  import wdt_pkg::*;

  localparam int unsigned IDX_LSB = 2;

  reg_idx_e          idx;
  logic              wr_en, ctrl_wr, code_ok, ctrl_acc;
  logic              trig, tick, run, irq_hit;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt;

  logic [TO_W-1:0]   irq_to_q, irq_to_d, res_to_q, res_to_d;
  logic              wen_q, wen_d;
  logic              raw_q, raw_d;
  logic              mask_q, mask_d;

  assign idx      = reg_idx_e'(bus_addr_i[IDX_LSB +: IDX_W]);
  assign wr_en    = bus_sel_i && bus_wr_i;
  assign ctrl_wr  = wr_en && (idx == IDX_CTRL);
  assign code_ok  = (bus_wdata_i[CODE_W-1:0] == code);
  assign ctrl_acc = ctrl_wr && code_ok;
  assign trig     = ctrl_acc && bus_wdata_i[BIT_TRIG];

  wdt_codegen #(
    .W     (CODE_W),
    .TAP_A (20),
    .TAP_B (17),
    .SEED  (CODE_SEED)
  ) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (ctrl_acc),
    .code_o (code)
  );

  wdt_prescale #(
    .DIV (TICK_DIV)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (run),
    .clr_i  (trig),
    .tick_o (tick)
  );

  wdt_countdown #(
    .TO_W  (TO_W),
    .CNT_W (CNT_W)
  ) u_cd (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig),
    .tick_i    (tick),
    .irq_to_i  (irq_to_q),
    .res_to_i  (res_to_q),
    .cnt_o     (cnt),
    .run_o     (run),
    .irq_hit_o (irq_hit),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    irq_to_d = irq_to_q;
    res_to_d = res_to_q;
    wen_d    = wen_q;
    raw_d    = raw_q;
    mask_d   = mask_q;
    if (ctrl_acc) wen_d = bus_wdata_i[BIT_WEN];
    if (wr_en && wen_q && (idx == IDX_IRQ_TO)) irq_to_d = bus_wdata_i[TO_W-1:0];
    if (wr_en && wen_q && (idx == IDX_RES_TO)) res_to_d = bus_wdata_i[TO_W-1:0];
    if (wr_en && (idx == IDX_MSK_SET) && bus_wdata_i[0]) mask_d = 1'b1;
    if (wr_en && (idx == IDX_MSK_CLR) && bus_wdata_i[0]) mask_d = 1'b0;
    if (irq_hit) begin
      raw_d = 1'b1;
    end else if ((wr_en && (idx == IDX_RAW) && bus_wdata_i[0]) ||
                 (ctrl_acc && bus_wdata_i[BIT_IRQ])) begin
      raw_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_to_q <= '0;
      res_to_q <= '0;
      wen_q    <= 1'b0;
      raw_q    <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      irq_to_q <= irq_to_d;
      res_to_q <= res_to_d;
      wen_q    <= wen_d;
      raw_q    <= raw_d;
      mask_q   <= mask_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (idx)
      IDX_CTRL: begin
        bus_rdata_o[CODE_W-1:0] = code;
        bus_rdata_o[BIT_IRQ]    = raw_q;
        bus_rdata_o[BIT_WEN]    = wen_q;
      end
      IDX_COUNT:   bus_rdata_o[CNT_W-1:0] = cnt;
      IDX_IRQ_TO:  bus_rdata_o[TO_W-1:0]  = irq_to_q;
      IDX_RES_TO:  bus_rdata_o[TO_W-1:0]  = res_to_q;
      IDX_RAW:     bus_rdata_o[0]         = raw_q;
      IDX_MASKED:  bus_rdata_o[0]         = raw_q & mask_q;
      IDX_MSK_SET: bus_rdata_o[0]         = mask_q;
      IDX_MSK_CLR: bus_rdata_o[0]         = mask_q;
      default:     bus_rdata_o            = '0;
    endcase
  end

  assign irq_o = raw_q & mask_q;

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !code_ok) |=> $stable(wen_q)); // R3
  AST_TO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wen_q) |=> $stable(irq_to_q) && $stable(res_to_q)); // R5
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |=> raw_q); // R7
  AST_TRIG_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_CTRL) |-> !bus_rdata_o[BIT_TRIG]); // R2
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int LIMIT      = 100000;

  logic        clk, rst_n, sel, wr;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, rstreq;
  int          checks, errors, cycles;
  logic        done;

  wdt_guard #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rstreq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] step(input logic [19:0] c);
    return {c[18:0], c[19] ^ c[16]};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; sel = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 0; wr = 0; wdata = 0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ctrl(input logic [31:0] bits);
    logic [31:0] r;
    rd_reg(5'h00, r);
    wr_reg(5'h00, bits | {12'h0, r[19:0]});
  endtask

  task automatic setup(input logic [15:0] ito, input logic [15:0] rto);
    ctrl(32'h8000_0000);
    wr_reg(5'h08, {16'h0, ito});
    wr_reg(5'h0C, {16'h0, rto});
  endtask

  task automatic t_reset();
    logic [31:0] r;
    do_reset();
    rd_reg(5'h00, r); chk("R1 ctrl", r, 32'h0005_A5A5);
    rd_reg(5'h04, r); chk("R1 count", r, 0);
    rd_reg(5'h08, r); chk("R1 irq_to", r, 0);
    rd_reg(5'h10, r); chk("R1 raw", r, 0);
    rd_reg(5'h18, r); chk("R1 mask", r, 0);
    chk("R1 pins", {30'h0, irq, rstreq}, 0);
  endtask

  task automatic t_code();
    logic [31:0] r, r2;
    logic [19:0] c0;
    do_reset();
    rd_reg(5'h00, r); c0 = r[19:0];
    wr_reg(5'h00, {12'h0, c0} | 32'h8000_0000);
    rd_reg(5'h00, r);
    chk("R4 advance", {12'h0, r[19:0]}, {12'h0, step(c0)});
    chk("R2 wen bit", {31'h0, r[31]}, 1);
    wr_reg(5'h00, {12'h0, c0} | 32'h1000_0000);
    rd_reg(5'h00, r2);
    chk("R4 old code rejected", r2, r);
    rd_reg(5'h04, r); chk("R4 no trigger on stale code", r, 0);
  endtask

  task automatic t_bad();
    logic [31:0] r, r0;
    do_reset();
    rd_reg(5'h00, r0);
    wr_reg(5'h00, ((r0 ^ 32'h1) & 32'hFFFFF) | 32'h9100_0000);
    rd_reg(5'h00, r); chk("R3 bad code no change", r, r0);
    wr_reg(5'h08, 32'h5);
    rd_reg(5'h08, r); chk("R5 locked timeout", r, 0);
  endtask

  task automatic t_lock();
    logic [31:0] r;
    do_reset();
    setup(16'h1234, 16'h0042);
    rd_reg(5'h08, r); chk("R5 irq_to written", r, 32'h1234);
    rd_reg(5'h0C, r); chk("R5 res_to written", r, 32'h0042);
    ctrl(32'h0);
    wr_reg(5'h08, 32'h7);
    rd_reg(5'h08, r); chk("R5 relocked", r, 32'h1234);
  endtask

  task automatic t_run();
    logic [31:0] r;
    do_reset();
    setup(16'd3, 16'd2);
    ctrl(32'h1000_0000);
    rd_reg(5'h00, r); chk("R2 trig reads 0", {31'h0, r[28]}, 0);
    rd_reg(5'h04, r); chk("R6 load sum", r, 5);
    repeat (3) @(negedge clk);
    rd_reg(5'h04, r); chk("R6 before tick", r, 5);
    @(negedge clk);
    rd_reg(5'h04, r); chk("R6 first tick", r, 4);
    repeat (7) @(negedge clk);
    rd_reg(5'h10, r); chk("R7 raw before", r, 0);
    @(negedge clk);
    rd_reg(5'h10, r); chk("R7 raw at irq_to", r, 1);
    chk("R11 irq_o masked off", {31'h0, irq}, 0);
    rd_reg(5'h14, r); chk("R11 masked view off", r, 0);
    wr_reg(5'h18, 32'h1);
    chk("R11 irq_o on", {31'h0, irq}, 1);
    rd_reg(5'h1C, r); chk("R11 mask read", r, 1);
    wr_reg(5'h1C, 32'h0);
    rd_reg(5'h14, r); chk("R11 clear with 0 no effect", r, 1);
    wr_reg(5'h1C, 32'h1);
    chk("R11 mask cleared", {31'h0, irq}, 0);
    repeat (4) @(negedge clk);
    chk("R8 rst before", {31'h0, rstreq}, 0);
    @(negedge clk);
    chk("R8 rst at zero", {31'h0, rstreq}, 1);
    ctrl(32'h1000_0000);
    repeat (3) @(negedge clk);
    chk("R8 sticky after retrigger", {31'h0, rstreq}, 1);
  endtask

  task automatic t_clear();
    logic [31:0] r;
    do_reset();
    setup(16'd2, 16'd8);
    ctrl(32'h1000_0000);
    repeat (8) @(negedge clk);
    rd_reg(5'h10, r); chk("R7 raw set", r, 1);
    wr_reg(5'h10, 32'h0);
    rd_reg(5'h10, r); chk("R10 write 0 keeps", r, 1);
    wr_reg(5'h10, 32'h1);
    rd_reg(5'h10, r); chk("R10 write 1 clears", r, 0);
    ctrl(32'h1000_0000);
    repeat (8) @(negedge clk);
    rd_reg(5'h10, r); chk("R10 raw set again", r, 1);
    rd_reg(5'h00, r);
    wr_reg(5'h00, ((r ^ 32'h2) & 32'hFFFFF) | 32'h0100_0000);
    rd_reg(5'h10, r); chk("R3 bad code no clear", r, 1);
    ctrl(32'h0100_0000);
    rd_reg(5'h10, r); chk("R10 ctrl clear", r, 0);
  endtask

  task automatic t_stop();
    logic [31:0] r;
    do_reset();
    setup(16'd2, 16'd0);
    ctrl(32'h1000_0000);
    repeat (20) @(negedge clk);
    rd_reg(5'h04, r); chk("R9 counter held", r, 2);
    chk("R9 no reset", {31'h0, rstreq}, 0);
  endtask

  task automatic t_retrig();
    logic [31:0] r;
    do_reset();
    setup(16'd4, 16'd4);
    ctrl(32'h1000_0000);
    repeat (7) @(negedge clk);
    ctrl(32'h1000_0000);
    rd_reg(5'h04, r); chk("R12 reload", r, 8);
    repeat (4) @(negedge clk);
    rd_reg(5'h04, r); chk("R12 after reload tick", r, 7);
    ctrl(32'h0);
    repeat (4) @(negedge clk);
    rd_reg(5'h04, r); chk("R12 no-trigger write keeps running", r, 6);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    t_reset();
    t_code();
    t_bad();
    t_lock();
    t_run();
    t_clear();
    t_stop();
    t_retrig();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cycles = 0;
    while (cycles < LIMIT) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule